// File: doc/BRIEF.md
# Per-CPU Banked Level Interrupt Aggregator

This block collects a set of level-sensitive peripheral interrupt lines and produces one active-high interrupt output for each CPU in the system. Every CPU owns a private bank of mask and status words. A line reaches a given CPU only when that CPU's bank has the matching mask bit set. Setting the bit in several banks sends one peripheral to several CPUs. There is no edge capture, polarity control, prioritisation or vectoring. A CPU that takes its interrupt reads every status word of its own bank to learn which sources are active.

The line count `NUM_IRQ` must be 32, 64 or 128. This gives `NW = NUM_IRQ/32` mask words and `NW` status words per bank. Each bank spans eight 32-bit word slots (0x20 bytes), selected by `reg_word`. Slots `0..NW-1` hold the status words and slots `NW..2*NW-1` hold the mask words, lowest interrupt numbers first. Bit n of word k stands for line 32*k+n. `reg_sel` picks the bank.

The register port is a plain control interface with no valid/ready pair and no back-pressure:
- A write is taken on every clock edge where `reg_we` is high.
- Read data is a combinational function of `reg_sel`, `reg_word`, the lines and the masks.
- Masks change only through whole-word writes, so software changes single bits by read-modify-write.

Top module: `irqagg_top`

## Requirements
- R1: While reset is low and after it, every mask bit of every bank is 0, every `cpu_irq` bit is 0 and every word slot of every bank reads 0 until written. Reset is asynchronous.
- R2: Slot k with k < NW of bank c reads `irq_lines[32k+31:32k] AND mask word k of bank c`, combinationally in the same cycle as the inputs.
- R3: A write to slot NW+k of bank c replaces mask word k of that bank with `reg_wdata` at the clock edge. A read of that slot returns the value written.
- R4: Writes to status slots (0..NW-1) change no mask bit in any bank.
- R5: A write with `reg_sel` = c changes no mask bit of any other bank.
- R6: `cpu_irq[c]` goes high at the first clock edge after which any masked status bit of bank c is 1. This is exactly one register stage after the line or mask change.
- R7: `cpu_irq[c]` goes low at the first clock edge after all masked status bits of bank c are 0, whether the line fell or the mask was cleared. It stays high until that edge.
- R8: A line whose mask bit is set in several banks raises `cpu_irq` of each of those CPUs together.
- R9: With `reg_sel` ≥ NUM_CPU, writes change no mask bit and reads return 0.
- R10: Inputs are levels and are not stored: a pulse on a line while its mask bit is 0 leaves no pending state once the bit is later set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IRQ | Level interrupt inputs, active high |
| reg_we | input | 1 | Write strobe, taken on each clock edge where it is high |
| reg_sel | input | CPU_W | Bank (CPU) select |
| reg_word | input | 3 | Word slot within the bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| cpu_irq | output | NUM_CPU | One interrupt output per CPU, registered |

## Verification
Results fall due at three different times:
- Status reads depend only on the present inputs and masks, so the bench samples them one nanosecond after changing the address in the low clock phase.
- A mask write is visible on a read at the falling edge after the write edge.
- `cpu_irq` trails any line or mask change by exactly one rising edge.

To confirm that register stage, the bench checks `cpu_irq` both at the falling edge before that rising edge, where it must still hold the old value, and at the falling edge after it. All stimulus is driven on falling edges, so each check's cycle is fixed by counting rising edges.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int WORD_W     = 32;
  localparam int BANK_SLOTS = 8;
  localparam int SLOT_W     = $clog2(BANK_SLOTS);

  function automatic int words_for(input int lines);
    return lines / WORD_W;
  endfunction

  function automatic int sel_width(input int cpus);
    return (cpus <= 1) ? 1 : $clog2(cpus);
  endfunction
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NW*WORD_W-1:0]        lines,
  input  logic                        wr_hit,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NW-1:0][WORD_W-1:0]   mask_words,
  output logic [NW-1:0][WORD_W-1:0]   stat_words,
  output logic                        cpu_irq
);

  logic any_pend;

  for (genvar k = 0; k < NW; k++) begin : g_word
    logic [WORD_W-1:0] mask_r;
    logic              slot_hit;

    assign slot_hit = wr_hit && (slot == SLOT_W'(NW + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_r <= '0;
      else if (slot_hit) mask_r <= wdata;
    end

    assign mask_words[k] = mask_r;
    assign stat_words[k] = lines[k*WORD_W +: WORD_W] & mask_r;
  end

  assign any_pend = |stat_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= any_pend;
  end

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
  import irqagg_pkg::*;
#(
  parameter int NUM_CPU = 3,
  parameter int NW      = 4,
  parameter int CPU_W   = 2
) (
  input  logic [NUM_CPU-1:0][NW-1:0][WORD_W-1:0] stat_all,
  input  logic [NUM_CPU-1:0][NW-1:0][WORD_W-1:0] mask_all,
  input  logic [CPU_W-1:0]                       sel,
  input  logic [SLOT_W-1:0]                      slot,
  output logic [WORD_W-1:0]                      rdata
);

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (sel == CPU_W'(c)) begin
        for (int k = 0; k < NW; k++) begin
          if (slot == SLOT_W'(k))      rdata = stat_all[c][k];
          if (slot == SLOT_W'(NW + k)) rdata = mask_all[c][k];
        end
      end
    end
  end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter  int NUM_IRQ = 128,
  parameter  int NUM_CPU = 3,
  localparam int NW      = words_for(NUM_IRQ),
  localparam int CPU_W   = sel_width(NUM_CPU)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_lines,
  input  logic                 reg_we,
  input  logic [CPU_W-1:0]     reg_sel,
  input  logic [SLOT_W-1:0]    reg_word,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_CPU-1:0]   cpu_irq
);

  if (NUM_IRQ != 32 && NUM_IRQ != 64 && NUM_IRQ != 128) begin : g_bad_cfg
    $error("irqagg_top: NUM_IRQ must be 32, 64 or 128");
  end

  logic [NUM_CPU-1:0][NW-1:0][WORD_W-1:0] en_q;
  logic [NUM_CPU-1:0][NW-1:0][WORD_W-1:0] st_q;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic bank_wr;
    assign bank_wr = reg_we && (reg_sel == CPU_W'(c));

    irqagg_bank #(.NW(NW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .lines      (irq_lines),
      .wr_hit     (bank_wr),
      .slot       (reg_word),
      .wdata      (reg_wdata),
      .mask_words (en_q[c]),
      .stat_words (st_q[c]),
      .cpu_irq    (cpu_irq[c])
    );
  end

  irqagg_rdmux #(.NUM_CPU(NUM_CPU), .NW(NW), .CPU_W(CPU_W)) u_rdmux (
    .stat_all (st_q),
    .mask_all (en_q),
    .sel      (reg_sel),
    .slot     (reg_word),
    .rdata    (reg_rdata)
  );

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter  int NUM_IRQ = 128,
  parameter  int NUM_CPU = 3,
  localparam int NW      = words_for(NUM_IRQ),
  localparam int CPU_W   = sel_width(NUM_CPU)
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [NUM_IRQ-1:0]                     irq_lines,
  input logic                                   reg_we,
  input logic [CPU_W-1:0]                       reg_sel,
  input logic [SLOT_W-1:0]                      reg_word,
  input logic [WORD_W-1:0]                      reg_wdata,
  input logic [NUM_CPU-1:0]                     cpu_irq,
  input logic [NUM_CPU-1:0][NW-1:0][WORD_W-1:0] en_q
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (cpu_irq == '0));

  // R4
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_word < SLOT_W'(NW)) |=> $stable(en_q));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines == '0) |=> (cpu_irq == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    // R5
    bank_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_sel == CPU_W'(c)) |=> $stable(en_q[c]));

    for (genvar k = 0; k < NW; k++) begin : g_word
      // R3
      wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == CPU_W'(c) && reg_word == SLOT_W'(NW + k))
        |=> (en_q[c][k] == $past(reg_wdata)));
    end
  end

  if (NUM_CPU < (1 << CPU_W)) begin : g_badsel
    // R9
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel >= CPU_W'(NUM_CPU)) |=> $stable(en_q));
  end

endmodule

bind irqagg_top irqagg_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
  localparam int NUM_IRQ = 128;
  localparam int NUM_CPU = 3;
  localparam int NW      = NUM_IRQ / 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_IRQ-1:0] irq_lines;
  logic               reg_we;
  logic [1:0]         reg_sel;
  logic [2:0]         reg_word;
  logic [31:0]        reg_wdata;
  logic [31:0]        reg_rdata;
  logic [NUM_CPU-1:0] cpu_irq;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  irqagg_top #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) dut (.*);

  typedef struct packed {
    logic [1:0]  bank;
    logic [1:0]  k;
    logic [31:0] en;
    logic [31:0] ln;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{2'd0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    '{2'd1, 2'd1, 32'h0000_FFFF, 32'h1234_5678, 32'h0000_5678},
    '{2'd2, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    '{2'd0, 2'd3, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000},
    '{2'd1, 2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{2'd2, 2'd0, 32'hAAAA_5555, 32'hFFFF_0000, 32'hAAAA_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int s, input int w, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(s); reg_word = 3'(w); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int s, input int w, output logic [31:0] d);
    reg_sel = 2'(s); reg_word = 3'(w);
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_lines = '0; reg_we = 1'b0;
    reg_sel = '0; reg_word = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 cpu_irq in reset", 32'(cpu_irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
    for (int c = 0; c < NUM_CPU; c++)
      for (int w = 0; w < 2 * NW; w++) begin
        rd(c, w, d);
        chk($sformatf("R1 reset word bank%0d slot%0d", c, w), d, 32'h0);
      end

    // Vector table: R2 status masking, R6 output rise
    for (int i = 0; i < 6; i++) begin
      wr(VT[i].bank, NW + VT[i].k, VT[i].en);
      irq_lines[VT[i].k*32 +: 32] = VT[i].ln;
      @(negedge clk);
      rd(VT[i].bank, VT[i].k, d);
      chk($sformatf("R2 vec%0d status", i), d, VT[i].ex);
      chk($sformatf("R6 vec%0d cpu_irq", i), 32'(cpu_irq),
          (VT[i].ex != 0) ? (32'h1 << VT[i].bank) : 32'h0);
      irq_lines = '0;
      wr(VT[i].bank, NW + VT[i].k, 32'h0);
    end

    // R3 mask write and readback
    wr(1, 6, 32'hA5A5_0F0F);
    rd(1, 6, d);  chk("R3 mask readback", d, 32'hA5A5_0F0F);

    // R4 status write ignored
    wr(1, 2, 32'hFFFF_FFFF);
    rd(1, 6, d);  chk("R4 mask after status write", d, 32'hA5A5_0F0F);
    rd(1, 2, d);  chk("R4 status after status write", d, 32'h0);

    // R5 other banks untouched
    rd(0, 6, d);  chk("R5 bank0 untouched", d, 32'h0);
    rd(2, 6, d);  chk("R5 bank2 untouched", d, 32'h0);

    // R9 out-of-range bank select
    wr(3, 6, 32'hFFFF_FFFF);
    rd(0, 6, d);  chk("R9 bank0 after bad sel", d, 32'h0);
    rd(1, 6, d);  chk("R9 bank1 after bad sel", d, 32'hA5A5_0F0F);
    rd(2, 6, d);  chk("R9 bank2 after bad sel", d, 32'h0);
    irq_lines = '1;
    rd(3, 0, d);  chk("R9 read bad sel", d, 32'h0);
    irq_lines = '0;
    wr(1, 6, 32'h0);

    // R6 latency on a mask write with the line already high
    irq_lines[70] = 1'b1;
    @(negedge clk);
    chk("R6 masked line stays low", 32'(cpu_irq), 32'h0);
    wr(1, 6, 32'h0000_0040);
    chk("R6 not before register stage", 32'(cpu_irq), 32'h0);
    rd(1, 2, d);  chk("R2 status immediate", d, 32'h0000_0040);
    @(negedge clk);
    chk("R6 rise", 32'(cpu_irq), 32'h2);

    // R7 fall on line drop
    irq_lines[70] = 1'b0;
    #1;
    chk("R7 held until edge", 32'(cpu_irq), 32'h2);
    @(negedge clk);
    chk("R7 fall on line", 32'(cpu_irq), 32'h0);

    // R7 fall on mask clear
    irq_lines[70] = 1'b1;
    @(negedge clk);
    chk("R7 rise again", 32'(cpu_irq), 32'h2);
    wr(1, 6, 32'h0);
    chk("R7 held one stage after mask clear", 32'(cpu_irq), 32'h2);
    @(negedge clk);
    chk("R7 fall on mask clear", 32'(cpu_irq), 32'h0);

    // R8 one line routed to two CPUs
    wr(0, 6, 32'h0000_0040);
    wr(2, 6, 32'h0000_0040);
    @(negedge clk);
    chk("R8 fan-out", 32'(cpu_irq), 32'h5);
    irq_lines = '0;
    wr(0, 6, 32'h0);
    wr(2, 6, 32'h0);

    // R10 no latching of a pulse while masked
    irq_lines[5] = 1'b1;
    @(negedge clk);
    irq_lines[5] = 1'b0;
    @(negedge clk);
    chk("R10 masked pulse", 32'(cpu_irq), 32'h0);
    wr(0, 4, 32'h0000_0020);
    @(negedge clk);
    chk("R10 no pending after enable", 32'(cpu_irq), 32'h0);
    rd(0, 0, d);  chk("R10 status after enable", d, 32'h0);
    wr(0, 4, 32'h0);

    // R1 asynchronous reset mid-run
    wr(2, 4, 32'hFFFF_FFFF);
    irq_lines[31:0] = 32'h1;
    @(negedge clk);
    chk("R1 pre-reset high", 32'(cpu_irq), 32'h4);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset output", 32'(cpu_irq), 32'h0);
    rd(2, 4, d);  chk("R1 async reset mask", d, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    irq_lines = '0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule